// File: doc/BRIEF.md
# Bit-serial framed SPI slave

This block is an SPI slave that moves exactly one byte per transaction inside a fixed frame of twelve rising SCLK edges. A frame opens with a start bit. Two setup bits follow, giving the direction and the target. Eight data bits then travel most significant bit first. The last edge carries a single status bit that the slave drives on MISO to tell the master whether the transfer took effect. The slave select input is active high and must stay high for the whole frame. SCLK, SS and MOSI are all taken into the system clock domain through two-flop synchronisers, and edges are detected there. The system clock must run at least four times faster than SCLK.

On the internal side there are two small show-ahead FIFOs. The receive FIFO collects bytes that the master writes, and internal logic drains it. The transmit FIFO is filled by internal logic and drained by master reads. A status byte reports two flags: receive FIFO full and transmit FIFO empty. The master can read this byte, and it is also visible on a port. A buffer changes only on the final edge of a frame that completes. A frame cut short by SS falling leaves both FIFOs untouched.

Top module: `bitser_spi_slave`

## Requirements
- R1: A frame starts only on a rising SCLK edge that sees SS and MOSI both high. Rising edges with SS high and MOSI low do not start a frame. Edges with SS low do not start a frame either.
- R2: The two bits after the start bit are the direction bit and then the target bit. The codes are 00 = data write, 10 = data read, 11 = status read and 01 = unused. Each frame is exactly 12 rising SCLK edges long, and the status bit is sampled on edge 12.
- R3: In a data write, MOSI is sampled on edges 4 to 11, most significant bit first. If the receive FIFO was not full, the byte is stored and the status bit is 0. If it was full, the byte is dropped and the status bit is 1.
- R4: In a data read, the head of the transmit FIFO is driven on MISO, most significant bit first, and the master samples it on edges 4 to 11. If a byte was present, it is removed and the status bit is 0. If the FIFO was empty, the status bit is 1 and the byte repeats the last byte successfully read, which is 0x00 after reset.
- R5: A status read returns a byte with bit 0 = receive FIFO full, bit 1 = transmit FIFO empty and bits 7..2 = 0, followed by a status bit of 0. The same byte is on status_o.
- R6: Status reads may follow one another with SS held high. After a data write or data read, no new frame is recognised until SS has gone low.
- R7: If SS falls before edge 12, the frame is aborted, neither FIFO changes, and the slave returns to idle.
- R8: For the unused code 01, no FIFO changes, MISO is 0 during the data bits and the status bit is 1.
- R9: MISO is 0 whenever no frame is in progress, and it is 0 during the data bits of a write.
- R10: Both FIFOs deliver bytes in arrival order with show-ahead data. A push into the full transmit FIFO and a pop from the empty receive FIFO are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI clock from the master |
| ss_i | input | 1 | Slave select, active high |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data and status bit to the master |
| rx_pop_i | input | 1 | Remove the head of the receive FIFO |
| rx_data_o | output | 8 | Head of the receive FIFO |
| rx_valid_o | output | 1 | Receive FIFO not empty |
| rx_full_o | output | 1 | Receive FIFO full |
| tx_push_i | input | 1 | Push tx_data_i into the transmit FIFO |
| tx_data_i | input | 8 | Byte to queue for master reads |
| tx_full_o | output | 1 | Transmit FIFO full |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| status_o | output | 8 | Status byte, as returned by a status read |

## Verification
The bench writes 0x1E and 0xA5. Because 0x1E bit-reversed is 0x78, this pair separates most-significant-first order from the reverse. It then fills the receive FIFO to its depth and sends one more byte, which shows that an accepted write and a dropped write give different status bits and different FIFO contents. Reads are issued against both an empty and a loaded transmit FIFO, which separates a fresh byte from a stale repeat. Status reads are chained with SS held high, while a data frame attempted with SS still high must be ignored. Aborted reads and writes, the unused code, and edges without a valid start condition each show that the FIFO contents stay unchanged.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_DATA, ST_STAT, ST_WAITLOW
  } frame_st_e;

  // {direction, target}
  typedef enum logic [1:0] {
    CMD_WR     = 2'b00,
    CMD_UNUSED = 2'b01,
    CMD_RD     = 2'b10,
    CMD_STAT   = 2'b11
  } cmd_e;
endpackage

// File: rtl/bss_sync.sv
module bss_sync #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] s1_q, s2_q, s3_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g] <= 1'b0;
        s2_q[g] <= 1'b0;
        s3_q[g] <= 1'b0;
      end else begin
        s1_q[g] <= d_i[g];
        s2_q[g] <= s1_q[g];
        s3_q[g] <= s2_q[g];
      end
    end
    assign rise_o[g] = s2_q[g] & ~s3_q[g];
  end

  assign q_o = s2_q;
endmodule

// File: rtl/bss_fifo.sv
module bss_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      end
      if (do_pop) rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  a_r10_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= (AW+1)'(DEPTH));
  a_r10_full_holds_on_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> full_o);
endmodule

// File: rtl/bss_frame.sv
module bss_frame
  import bss_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_rise_i,
  input  logic          ss_i,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          rx_full_i,
  output logic          rx_push_o,
  output logic [DW-1:0] rx_data_o,
  input  logic          tx_empty_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          tx_pop_o,
  input  logic [DW-1:0] stat_byte_i
);
  localparam int unsigned CW = $clog2(DW);
  localparam logic [CW-1:0] BIT_LAST = CW'(DW - 1);

  frame_st_e     st_q;
  cmd_e          cmd_q, setup_cmd;
  logic [CW-1:0] cnt_q;
  logic          dir_q, flag_q;
  logic [DW-1:0] sh_q, last_tx_q;

  assign setup_cmd = cmd_e'({dir_q, mosi_i});
  assign rx_data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cmd_q     <= CMD_WR;
      cnt_q     <= '0;
      dir_q     <= 1'b0;
      flag_q    <= 1'b0;
      sh_q      <= '0;
      last_tx_q <= '0;
      rx_push_o <= 1'b0;
      tx_pop_o  <= 1'b0;
    end else begin
      rx_push_o <= 1'b0;
      tx_pop_o  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (sclk_rise_i && ss_i && mosi_i) begin
            st_q  <= ST_SETUP;
            cnt_q <= '0;
          end
        end
        ST_SETUP: begin
          if (!ss_i) st_q <= ST_IDLE;
          else if (sclk_rise_i) begin
            if (cnt_q == '0) begin
              dir_q <= mosi_i;
              cnt_q <= CW'(1);
            end else begin
              cmd_q <= setup_cmd;
              cnt_q <= '0;
              st_q  <= ST_DATA;
              case (setup_cmd)
                CMD_RD: begin
                  sh_q   <= tx_empty_i ? last_tx_q : tx_data_i;
                  flag_q <= tx_empty_i;
                end
                CMD_STAT: begin
                  sh_q   <= stat_byte_i;
                  flag_q <= 1'b0;
                end
                CMD_WR: begin
                  sh_q   <= '0;
                  flag_q <= 1'b0;
                end
                default: begin
                  sh_q   <= '0;
                  flag_q <= 1'b1;
                end
              endcase
            end
          end
        end
        ST_DATA: begin
          if (!ss_i) st_q <= ST_IDLE;
          else if (sclk_rise_i) begin
            sh_q  <= {sh_q[DW-2:0], (cmd_q == CMD_WR) ? mosi_i : 1'b0};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == BIT_LAST) begin
              st_q <= ST_STAT;
              if (cmd_q == CMD_WR) flag_q <= rx_full_i;
            end
          end
        end
        ST_STAT: begin
          if (!ss_i) st_q <= ST_IDLE;
          else if (sclk_rise_i) begin
            if (cmd_q == CMD_WR && !flag_q) rx_push_o <= 1'b1;
            if (cmd_q == CMD_RD && !flag_q) begin
              tx_pop_o  <= 1'b1;
              last_tx_q <= tx_data_i;
            end
            st_q <= (cmd_q == CMD_STAT) ? ST_IDLE : ST_WAITLOW;
          end
        end
        ST_WAITLOW: if (!ss_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    miso_o = 1'b0;
    if (st_q == ST_DATA && (cmd_q == CMD_RD || cmd_q == CMD_STAT)) miso_o = sh_q[DW-1];
    else if (st_q == ST_STAT) miso_o = flag_q;
  end

  a_r9_miso_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE || st_q == ST_WAITLOW) |-> !miso_o);
  a_r3_no_write_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> !rx_full_i);
  a_r4_no_pop_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> !tx_empty_i);
  a_r7_commit_needs_ss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_o || tx_pop_o) |-> $past(ss_i));
  a_r2_single_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_push_o, tx_pop_o}));
endmodule

// File: rtl/bitser_spi_slave.sv
module bitser_spi_slave #(
  parameter int unsigned DW       = 8,
  parameter int unsigned RX_DEPTH = 4,
  parameter int unsigned TX_DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          ss_i,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o,
  output logic          rx_full_o,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          tx_full_o,
  output logic          tx_empty_o,
  output logic [DW-1:0] status_o
);
  logic [2:0]    pin_q, pin_rise;
  logic          rx_push, rx_empty, tx_pop;
  logic [DW-1:0] rx_wdata, tx_head;

  bss_sync #(.WIDTH(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, ss_i, mosi_i}),
    .q_o   (pin_q),
    .rise_o(pin_rise)
  );

  assign status_o   = {{(DW-2){1'b0}}, tx_empty_o, rx_full_o};
  assign rx_valid_o = !rx_empty;

  bss_frame #(.DW(DW)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_rise_i(pin_rise[2]),
    .ss_i       (pin_q[1]),
    .mosi_i     (pin_q[0]),
    .miso_o     (miso_o),
    .rx_full_i  (rx_full_o),
    .rx_push_o  (rx_push),
    .rx_data_o  (rx_wdata),
    .tx_empty_i (tx_empty_o),
    .tx_data_i  (tx_head),
    .tx_pop_o   (tx_pop),
    .stat_byte_i(status_o)
  );

  bss_fifo #(.DW(DW), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (rx_push),
    .data_i (rx_wdata),
    .pop_i  (rx_pop_i),
    .data_o (rx_data_o),
    .full_o (rx_full_o),
    .empty_o(rx_empty)
  );

  bss_fifo #(.DW(DW), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (tx_push_i),
    .data_i (tx_data_i),
    .pop_i  (tx_pop),
    .data_o (tx_head),
    .full_o (tx_full_o),
    .empty_o(tx_empty_o)
  );
endmodule

// File: tb/tb_bitser_spi_slave.sv
module tb_bitser_spi_slave;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DEPTH = 4;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       sclk_i = 1'b0, ss_i = 1'b0, mosi_i = 1'b0;
  logic       miso_o;
  logic       rx_pop_i = 1'b0, tx_push_i = 1'b0;
  logic [7:0] rx_data_o, tx_data_i = '0, status_o;
  logic       rx_valid_o, rx_full_o, tx_full_o, tx_empty_o;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bitser_spi_slave dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .ss_i(ss_i), .mosi_i(mosi_i),
    .miso_o(miso_o), .rx_pop_i(rx_pop_i), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .rx_full_o(rx_full_o), .tx_push_i(tx_push_i), .tx_data_i(tx_data_i),
    .tx_full_o(tx_full_o), .tx_empty_o(tx_empty_o), .status_o(status_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bit_cyc(input logic mo, output logic mi);
    mosi_i = mo;
    wait_clk(4);
    mi = miso_o;
    sclk_i = 1'b1;
    wait_clk(4);
    sclk_i = 1'b0;
  endtask

  task automatic xfer(input logic d, input logic a, input logic [7:0] wb, input bit hold,
                      output logic [7:0] rb, output logic st);
    logic m;
    ss_i = 1'b1;
    wait_clk(3);
    bit_cyc(1'b1, m);
    bit_cyc(d, m);
    bit_cyc(a, m);
    for (int i = 7; i >= 0; i--) begin
      bit_cyc(wb[i], m);
      rb[i] = m;
    end
    bit_cyc(1'b0, st);
    if (!hold) ss_i = 1'b0;
    wait_clk(6);
  endtask

  task automatic tx_push(input logic [7:0] b);
    tx_data_i = b; tx_push_i = 1'b1;
    wait_clk(1);
    tx_push_i = 1'b0;
  endtask

  task automatic rx_pop_chk(input string req, input logic [7:0] exp);
    chk(req, {31'd0, rx_valid_o}, 32'd1);
    chk(req, {24'd0, rx_data_o}, {24'd0, exp});
    rx_pop_i = 1'b1;
    wait_clk(1);
    rx_pop_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 reset miso", {31'd0, miso_o}, 32'd0);
    chk("R10 reset rx empty", {31'd0, rx_valid_o}, 32'd0);
    chk("R5 reset status_o", {24'd0, status_o}, 32'h02);
  endtask

  task automatic t_write_basic;
    logic [7:0] rb; logic st;
    xfer(1'b0, 1'b0, 8'h1E, 1'b0, rb, st);
    chk("R3 write status bit", {31'd0, st}, 32'd0);
    chk("R9 write miso data", {24'd0, rb}, 32'd0);
    xfer(1'b0, 1'b0, 8'hA5, 1'b0, rb, st);
    rx_pop_chk("R3 msb-first 0x1E", 8'h1E);
    rx_pop_chk("R3 second byte", 8'hA5);
    chk("R10 rx drained", {31'd0, rx_valid_o}, 32'd0);
  endtask

  task automatic t_write_full;
    logic [7:0] rb; logic st;
    for (int i = 0; i < DEPTH; i++) begin
      xfer(1'b0, 1'b0, 8'h40 + 8'(i), 1'b0, rb, st);
      chk("R3 fill accept", {31'd0, st}, 32'd0);
    end
    chk("R3 rx full flag", {31'd0, rx_full_o}, 32'd1);
    xfer(1'b0, 1'b0, 8'hEE, 1'b0, rb, st);
    chk("R3 full write rejected", {31'd0, st}, 32'd1);
    // chained status reads with SS high
    xfer(1'b1, 1'b1, 8'h00, 1'b1, rb, st);
    chk("R5 status byte full", {24'd0, rb}, 32'h03);
    chk("R5 status bit", {31'd0, st}, 32'd0);
    xfer(1'b1, 1'b1, 8'h00, 1'b0, rb, st);
    chk("R6 chained status read", {24'd0, rb}, 32'h03);
    for (int i = 0; i < DEPTH; i++) rx_pop_chk("R10 rx order", 8'h40 + 8'(i));
    chk("R3 dropped byte absent", {31'd0, rx_valid_o}, 32'd0);
  endtask

  task automatic t_read;
    logic [7:0] rb; logic st;
    xfer(1'b1, 1'b0, 8'h00, 1'b0, rb, st);
    chk("R4 empty read status", {31'd0, st}, 32'd1);
    chk("R4 stale byte after reset", {24'd0, rb}, 32'h00);
    tx_push(8'h3C);
    tx_push(8'hC3);
    chk("R5 status_o tx loaded", {24'd0, status_o}, 32'h00);
    xfer(1'b1, 1'b0, 8'h00, 1'b0, rb, st);
    chk("R4 read byte 1", {24'd0, rb}, 32'h3C);
    chk("R4 read status 1", {31'd0, st}, 32'd0);
    xfer(1'b1, 1'b0, 8'h00, 1'b0, rb, st);
    chk("R4 read byte 2", {24'd0, rb}, 32'hC3);
    chk("R4 tx emptied", {31'd0, tx_empty_o}, 32'd1);
    xfer(1'b1, 1'b0, 8'h00, 1'b0, rb, st);
    chk("R4 stale status", {31'd0, st}, 32'd1);
    chk("R4 stale repeats last", {24'd0, rb}, 32'hC3);
  endtask

  task automatic t_abort;
    logic m; logic [7:0] rb; logic st;
    tx_push(8'hAA);
    ss_i = 1'b1; wait_clk(3);
    bit_cyc(1'b1, m); bit_cyc(1'b1, m); bit_cyc(1'b0, m);
    for (int i = 0; i < 3; i++) bit_cyc(1'b0, m);
    ss_i = 1'b0; wait_clk(6);
    chk("R7 aborted read keeps tx", {31'd0, tx_empty_o}, 32'd0);
    ss_i = 1'b1; wait_clk(3);
    bit_cyc(1'b1, m); bit_cyc(1'b0, m); bit_cyc(1'b0, m);
    for (int i = 0; i < 8; i++) bit_cyc(1'b1, m);
    ss_i = 1'b0; wait_clk(6);
    chk("R7 aborted write not stored", {31'd0, rx_valid_o}, 32'd0);
    chk("R9 miso idle after abort", {31'd0, miso_o}, 32'd0);
    xfer(1'b1, 1'b0, 8'h00, 1'b0, rb, st);
    chk("R7 byte still readable", {24'd0, rb}, 32'hAA);
    chk("R7 byte fresh", {31'd0, st}, 32'd0);
  endtask

  task automatic t_unused;
    logic [7:0] rb; logic st;
    xfer(1'b0, 1'b1, 8'hFF, 1'b0, rb, st);
    chk("R8 unused status bit", {31'd0, st}, 32'd1);
    chk("R8 unused miso data", {24'd0, rb}, 32'd0);
    chk("R8 unused no rx write", {31'd0, rx_valid_o}, 32'd0);
  endtask

  task automatic t_nostart;
    logic m;
    ss_i = 1'b1; wait_clk(3);
    for (int i = 0; i < 3; i++) bit_cyc(1'b0, m);
    ss_i = 1'b0; wait_clk(6);
    for (int i = 0; i < 12; i++) bit_cyc(1'b1, m);
    wait_clk(6);
    chk("R1 no frame without start", {31'd0, rx_valid_o}, 32'd0);
    chk("R1 tx untouched", {31'd0, tx_empty_o}, 32'd1);
    chk("R1 miso quiet", {31'd0, miso_o}, 32'd0);
  endtask

  task automatic t_ss_hold;
    logic [7:0] rb; logic st;
    xfer(1'b0, 1'b0, 8'h11, 1'b1, rb, st);
    xfer(1'b0, 1'b0, 8'h22, 1'b0, rb, st);
    rx_pop_chk("R6 first write stored", 8'h11);
    chk("R6 write with SS held ignored", {31'd0, rx_valid_o}, 32'd0);
    xfer(1'b0, 1'b0, 8'h33, 1'b0, rb, st);
    rx_pop_chk("R2 frame after SS low", 8'h33);
  endtask

  task automatic t_tx_overflow;
    logic [7:0] rb; logic st;
    for (int i = 0; i <= DEPTH; i++) tx_push(8'h80 + 8'(i));
    chk("R10 tx full", {31'd0, tx_full_o}, 32'd1);
    for (int i = 0; i < DEPTH; i++) begin
      xfer(1'b1, 1'b0, 8'h00, 1'b0, rb, st);
      chk("R10 tx order", {24'd0, rb}, {24'd0, 8'h80 + 8'(i)});
    end
    chk("R10 extra push ignored", {31'd0, tx_empty_o}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst_ni = 1'b1;
    wait_clk(4);
    t_reset();
    t_write_basic();
    t_write_full();
    t_read();
    t_abort();
    t_unused();
    t_nostart();
    t_ss_hold();
    t_tx_overflow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule